// File: doc/BRIEF.md
# Stereo Audio Serial Port

This block is a double-buffered synchronous serial port that sits between a processor bus and a stereo audio converter. The converter owns the timing. It supplies the shift clock and a one-bit frame-sync pulse at the start of every sample pair. Each frame is one 32-bit word: the left sample (two's complement) sits in bits 31..16 and the right sample in bits 15..0. Bits travel most significant first, so the left sample goes out before the right one.

On the transmit path the processor writes a word into the transmit holding register. At the next frame start that word is copied into the transmit shift register and clocked out on `ser_dout`. The copy raises a one-cycle `tx_irq` and sets the transmit-ready flag, so software can supply the following word. On the receive path, bits from `ser_din` collect in a receive shift register. A complete word is handed to a buffer register, and from there to the receive data register once that register is free. That second transfer sets the receive-ready flag and pulses `rx_irq`.

The serial inputs are resynchronised into the core clock domain through `SYNC_STAGES` flops, and every shift action takes place on a detected edge of the external clock. Two finite-state machines do the shifting:

- **Transmitter:** states `TX_IDLE`, `TX_DRIVE` and `TX_HOLD`.
  - `TX_IDLE -> TX_DRIVE` when a rising edge sees frame sync high.
  - `TX_DRIVE -> TX_HOLD` when a rising edge consumes the bit on the pin.
  - `TX_HOLD -> TX_DRIVE` on a falling edge while bits remain.
  - `TX_HOLD -> TX_IDLE` on a falling edge after the last bit.
  - Any state goes to `TX_DRIVE` when a frame sync restarts the frame.
- **Receiver:** states `RX_IDLE` and `RX_SHIFT`.
  - `RX_IDLE -> RX_SHIFT` when a frame sync is seen.
  - `RX_SHIFT -> RX_IDLE` after the thirty-second data bit.
- **Receive buffer:** states `BUF_EMPTY` and `BUF_FULL`.
  - `BUF_EMPTY -> BUF_FULL` when a word completes.
  - `BUF_FULL -> BUF_EMPTY` when the word moves into the free data register.

Top module: `audio_serial_port`

## Requirements
- R1: After reset the control register (offset 2) reads 0x0002_0000: transmit-ready (bit 17) is 1, and receive-ready (bit 1), overrun (bit 2) and underrun (bit 18) are 0. After reset `tx_irq`, `rx_irq` and `ser_dout` are low and the receive data register (offset 1) reads 0.
- R2: A write to the transmit register (offset 0) clears transmit-ready (control bit 17).
- R3: On the rising shift-clock edge that samples frame sync high, the transmit register is copied to the shift register, transmit-ready is set, and `tx_irq` is high for exactly one core cycle.
- R4: The transmit word is sent MSB first. Bit 31 is valid at the first rising shift-clock edge after the frame-sync edge, and each further bit is valid at each following rising edge. The pin changes only after falling edges.
- R5: The 32 bits sampled on the rising edges that follow the frame-sync edge are assembled MSB first. The word reaches the receive data register (offset 1), receive-ready (bit 1) is set, and `rx_irq` pulses for one cycle.
- R6: Reading the receive data register clears receive-ready.
- R7: If a word completes while receive-ready is still 1, the sticky overrun flag (bit 2) is set. The unread word stays readable, and the new word is kept in the buffer. It is delivered, with a new `rx_irq`, after the read.
- R8: If a frame starts while transmit-ready is still 1, the previous transmit word is sent again and the sticky underrun flag (bit 18) is set.
- R9: Writing 1 to control bit 2 or bit 18 clears that sticky flag. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 transmit, 1 receive, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| tx_irq | output | 1 | One-cycle pulse: transmit word taken |
| rx_irq | output | 1 | One-cycle pulse: received word available |
| ser_clk | input | 1 | External shift clock |
| ser_fsync | input | 1 | External frame-sync pulse |
| ser_din | input | 1 | Serial receive data |
| ser_dout | output | 1 | Serial transmit data |

## Verification
The hardest state to reach from the ports is a receive overrun with a second word parked in the buffer register. That state exists only when two full frames arrive with no read of the receive data register between them. The bench plays two complete converter frames back to back without touching the bus. It then reads the first word and confirms that the buffered second word appears afterwards with its own interrupt. Underrun is reached in a similar way, by letting a frame start with no new transmit write. The bench then compares the word sent again, bit by bit, against the last one written.

// File: rtl/asp_pkg.sv
package asp_pkg;
    localparam int DATA_W = 32;

    localparam logic [1:0] REG_TXD = 2'd0;
    localparam logic [1:0] REG_RXD = 2'd1;
    localparam logic [1:0] REG_CTL = 2'd2;

    localparam int CTL_RX_RDY = 1;
    localparam int CTL_RX_OVR = 2;
    localparam int CTL_TX_RDY = 17;
    localparam int CTL_TX_UND = 18;

    typedef enum logic [1:0] {TX_IDLE, TX_DRIVE, TX_HOLD} tx_state_t;
    typedef enum logic {RX_IDLE, RX_SHIFT} rx_state_t;
    typedef enum logic {BUF_EMPTY, BUF_FULL} buf_state_t;
endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic fs_i,
    input  logic din_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic fs_lvl,
    output logic din_lvl
);
    localparam int CHAIN_W = 3 * STAGES;

    logic [CHAIN_W-1:0] chain;
    logic               sclk_prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {din_i, fs_i, sclk_i};
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[CHAIN_W-4:0], din_i, fs_i, sclk_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= chain[CHAIN_W-3];
    end

    assign sclk_rise = chain[CHAIN_W-3] & ~sclk_prev;
    assign sclk_fall = ~chain[CHAIN_W-3] & sclk_prev;
    assign fs_lvl    = chain[CHAIN_W-2];
    assign din_lvl   = chain[CHAIN_W-1];
endmodule

// File: rtl/asp_tx.sv
module asp_tx
    import asp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         fs_lvl,
    input  logic [W-1:0] load_word,
    output logic         frame_start,
    output logic         dout
);
    localparam int CW = $clog2(W + 1);

    tx_state_t      state_q, state_d;
    logic [W-1:0]   xsr;
    logic [CW-1:0]  bits_left;

    assign frame_start = sclk_rise & fs_lvl;
    assign dout        = xsr[W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            state_d = TX_DRIVE;
        end else begin
            unique case (state_q)
                TX_IDLE:  state_d = TX_IDLE;
                TX_DRIVE: if (sclk_rise) state_d = TX_HOLD;
                TX_HOLD:  if (sclk_fall) state_d = (bits_left == '0) ? TX_IDLE : TX_DRIVE;
                default:  state_d = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xsr       <= '0;
            bits_left <= '0;
        end else if (frame_start) begin
            xsr       <= load_word;
            bits_left <= CW'(W);
        end else begin
            if (state_q == TX_DRIVE && sclk_rise) bits_left <= bits_left - 1'b1;
            if (state_q == TX_HOLD && sclk_fall)  xsr <= xsr << 1;
        end
    end
endmodule

// File: rtl/asp_rx.sv
module asp_rx
    import asp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_rise,
    input  logic         fs_lvl,
    input  logic         din_lvl,
    output logic         word_valid,
    output logic [W-1:0] word
);
    localparam int CW = $clog2(W);

    rx_state_t     state_q, state_d;
    logic [CW-1:0] bit_cnt;
    logic          frame_start;
    logic          last_bit;

    assign frame_start = sclk_rise & fs_lvl;
    assign last_bit    = (bit_cnt == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            state_d = RX_SHIFT;
        end else begin
            unique case (state_q)
                RX_IDLE:  state_d = RX_IDLE;
                RX_SHIFT: if (sclk_rise && last_bit) state_d = RX_IDLE;
                default:  state_d = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word       <= '0;
            bit_cnt    <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (frame_start) begin
                bit_cnt <= '0;
            end else if (state_q == RX_SHIFT && sclk_rise) begin
                word    <= {word[W-2:0], din_lvl};
                bit_cnt <= bit_cnt + 1'b1;
                if (last_bit) word_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
    import asp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_irq,
    output logic              rx_irq,
    input  logic              ser_clk,
    input  logic              ser_fsync,
    input  logic              ser_din,
    output logic              ser_dout
);
    logic              s_rise, s_fall, s_fs, s_din;
    logic              tx_start;
    logic              rx_valid;
    logic [DATA_W-1:0] rx_word;

    logic [DATA_W-1:0] txdr, rbr, drr;
    logic              tx_rdy, rx_rdy, rx_ovr, tx_und;
    buf_state_t        buf_q, buf_d;
    logic              wr_txd, wr_ctl, rd_rxd, move;

    asp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(ser_clk), .fs_i(ser_fsync), .din_i(ser_din),
        .sclk_rise(s_rise), .sclk_fall(s_fall), .fs_lvl(s_fs), .din_lvl(s_din)
    );

    asp_tx #(.W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(s_rise), .sclk_fall(s_fall), .fs_lvl(s_fs),
        .load_word(txdr), .frame_start(tx_start), .dout(ser_dout)
    );

    asp_rx #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(s_rise), .fs_lvl(s_fs), .din_lvl(s_din),
        .word_valid(rx_valid), .word(rx_word)
    );

    assign wr_txd = bus_wr && bus_addr == REG_TXD;
    assign wr_ctl = bus_wr && bus_addr == REG_CTL;
    assign rd_rxd = bus_rd && bus_addr == REG_RXD;
    assign move   = (buf_q == BUF_FULL) && !rx_rdy;

    // receive buffer state register
    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= BUF_EMPTY;
        else        buf_q <= buf_d;
    end

    always_comb begin
        buf_d = buf_q;
        unique case (buf_q)
            BUF_EMPTY: if (rx_valid) buf_d = BUF_FULL;
            BUF_FULL:  if (!rx_valid && move) buf_d = BUF_EMPTY;
            default:   buf_d = BUF_EMPTY;
        endcase
    end

    // register file and flag outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txdr   <= '0;
            rbr    <= '0;
            drr    <= '0;
            tx_rdy <= 1'b1;
            rx_rdy <= 1'b0;
            rx_ovr <= 1'b0;
            tx_und <= 1'b0;
            tx_irq <= 1'b0;
            rx_irq <= 1'b0;
        end else begin
            tx_irq <= tx_start;
            rx_irq <= move;

            if (wr_txd)        txdr <= bus_wdata;
            if (wr_txd)        tx_rdy <= 1'b0;
            else if (tx_start) tx_rdy <= 1'b1;

            if (tx_start && tx_rdy)               tx_und <= 1'b1;
            else if (wr_ctl && bus_wdata[CTL_TX_UND]) tx_und <= 1'b0;

            if (rx_valid) rbr <= rx_word;
            if (move) begin
                drr    <= rbr;
                rx_rdy <= 1'b1;
            end else if (rd_rxd) begin
                rx_rdy <= 1'b0;
            end

            if (rx_valid && rx_rdy)                   rx_ovr <= 1'b1;
            else if (wr_ctl && bus_wdata[CTL_RX_OVR]) rx_ovr <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_TXD: bus_rdata = txdr;
            REG_RXD: bus_rdata = drr;
            REG_CTL: begin
                bus_rdata[CTL_RX_RDY] = rx_rdy;
                bus_rdata[CTL_RX_OVR] = rx_ovr;
                bus_rdata[CTL_TX_RDY] = tx_rdy;
                bus_rdata[CTL_TX_UND] = tx_und;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/audio_serial_port_chk.sv
module audio_serial_port_chk
    import asp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tx_irq,
    input logic              rx_irq,
    input logic              tx_rdy,
    input logic              rx_rdy,
    input logic              rx_ovr,
    input logic              tx_und
);
    AST_TX_WRITE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_TXD) |=> !tx_rdy); // R2
    AST_TX_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq); // R3
    AST_TX_READY_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_rdy) |-> tx_irq); // R3
    AST_RX_READY_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_rdy) |-> rx_irq); // R5
    AST_RX_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq); // R5
    AST_RX_READ_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_RXD) |=> !rx_rdy); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr && !(bus_wr && bus_addr == REG_CTL && bus_wdata[CTL_RX_OVR])) |=> rx_ovr); // R7
    AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_und && !(bus_wr && bus_addr == REG_CTL && bus_wdata[CTL_TX_UND])) |=> tx_und); // R8
endmodule

bind audio_serial_port audio_serial_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_rdy(tx_rdy),
    .rx_rdy(rx_rdy), .rx_ovr(rx_ovr), .tx_und(tx_und)
);

// File: tb/audio_serial_port_tb.sv
module audio_serial_port_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF       = 8;
    localparam int  NVEC       = 4;
    // {word written for transmit, word the converter sends}
    localparam logic [63:0] VEC [NVEC] = '{
        {32'hFFFF_0001, 32'h8000_0001},
        {32'h1234_ABCD, 32'h7FFF_8000},
        {32'h8000_7FFF, 32'hA5A5_5A5A},
        {32'h0F0F_F0F0, 32'h0000_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_irq, rx_irq;
    logic        ser_clk = 1'b0;
    logic        ser_fsync = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_dout;

    int n_chk = 0;
    int n_fail = 0;
    int tx_irq_cnt = 0;
    int rx_irq_cnt = 0;
    int wide_cnt = 0;
    logic tx_irq_d = 1'b0, rx_irq_d = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    audio_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .ser_clk(ser_clk), .ser_fsync(ser_fsync), .ser_din(ser_din), .ser_dout(ser_dout)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (tx_irq) tx_irq_cnt++;
            if (rx_irq) rx_irq_cnt++;
            if ((tx_irq && tx_irq_d) || (rx_irq && rx_irq_d)) wide_cnt++;
        end
        tx_irq_d <= tx_irq;
        rx_irq_d <= rx_irq;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic codec_frame(input logic [31:0] rxw, output logic [31:0] txw);
        ser_fsync = 1'b1; ser_din = 1'b0;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b1;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b0; ser_fsync = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            ser_din = rxw[i];
            repeat (HALF) @(negedge clk);
            txw[i] = ser_dout;
            ser_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, cap, last_tx;
        int t0, r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        cpu_read(2'd2, rd);
        check("R1 ctl", rd, 32'h0002_0000);
        check("R1 irqs/dout", {29'd0, tx_irq, rx_irq, ser_dout}, 32'd0);
        cpu_read(2'd1, rd);
        check("R1 rxd", rd, 32'd0);

        last_tx = '0;
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] txw, rxw;
            txw = VEC[v][63:32];
            rxw = VEC[v][31:0];
            cpu_write(2'd0, txw);
            cpu_read(2'd2, rd);
            check("R2 tx ready cleared", {31'd0, rd[17]}, 32'd0);
            t0 = tx_irq_cnt; r0 = rx_irq_cnt;
            codec_frame(rxw, cap);
            repeat (4) @(negedge clk);
            check("R4 serial out", cap, txw);
            check("R3 tx irq count", tx_irq_cnt - t0, 32'd1);
            check("R5 rx irq count", rx_irq_cnt - r0, 32'd1);
            cpu_read(2'd2, rd);
            check("R3/R5 ctl flags", rd, 32'h0002_0002);
            cpu_read(2'd1, rd);
            check("R5 rx word", rd, rxw);
            cpu_read(2'd2, rd);
            check("R6 rx ready cleared", {31'd0, rd[1]}, 32'd0);
            last_tx = txw;
        end
        check("R3/R5 irq width one cycle", wide_cnt, 32'd0);

        // R8: frame with no refill resends last word, sets underrun
        codec_frame(32'h1111_2222, cap);
        repeat (4) @(negedge clk);
        check("R8 resent word", cap, last_tx);
        cpu_read(2'd2, rd);
        check("R8 underrun flag", {31'd0, rd[18]}, 32'd1);
        cpu_read(2'd1, rd);

        // R9: write 0 keeps, write 1 clears
        cpu_write(2'd2, 32'd0);
        cpu_read(2'd2, rd);
        check("R9 underrun kept on 0", {31'd0, rd[18]}, 32'd1);
        cpu_write(2'd2, 32'h0004_0000);
        cpu_read(2'd2, rd);
        check("R9 underrun cleared", {31'd0, rd[18]}, 32'd0);

        // R7: two frames with no read in between
        codec_frame(32'hAAAA_0001, cap);
        codec_frame(32'hBBBB_0002, cap);
        repeat (4) @(negedge clk);
        cpu_read(2'd2, rd);
        check("R7 overrun flag", {31'd0, rd[2]}, 32'd1);
        r0 = rx_irq_cnt;
        cpu_read(2'd1, rd);
        check("R7 first word kept", rd, 32'hAAAA_0001);
        repeat (4) @(negedge clk);
        check("R7 buffered word irq", rx_irq_cnt - r0, 32'd1);
        cpu_read(2'd2, rd);
        check("R7 ready again, overrun sticky", {30'd0, rd[2], rd[1]}, 32'd3);
        cpu_read(2'd1, rd);
        check("R7 buffered word", rd, 32'hBBBB_0002);
        cpu_write(2'd2, 32'd0);
        cpu_read(2'd2, rd);
        check("R9 overrun kept on 0", {31'd0, rd[2]}, 32'd1);
        cpu_write(2'd2, 32'h0000_0004);
        cpu_read(2'd2, rd);
        check("R9 overrun cleared", {31'd0, rd[2]}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule